// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment and a 16-bit offset into a physical address. It shifts the segment left by four bits and adds the offset. The sum can reach 21 bits, so a gate on address bit 20 decides what happens to the carry out of the 1 MiB range. With the gate closed, bit 20 is forced to zero, so references at or above 1 MiB fold back to the bottom of memory. With the gate open, the carry passes through and the top referenceable location, FFFF:FFFF, reaches 10FFEFh.

The block also normalizes addresses. Given a 20-bit physical address, it returns the one segment:offset pair whose offset is at most 0Fh. The address path and the normalizer are purely combinational. The gate setting sits in a flop. That flop is loaded by a write strobe and comes out of reset in the wrapping state. A processor front end or a debug model uses the block to form addresses that behave like real mode in both compatibility settings.

Top module: `seg_addr_gen`

## Requirements
- R1: `addr_o` equals segment × 16 + offset whenever that sum is below 100000h, with the gate in either setting; for example 258C:0012 gives 258D2h.
- R2: After a synchronous active-low reset the gate is closed (masking), so FFFF:FFFF gives `addr_o` = 0FFEFh with `wrap_o` = 1. This holds even if the gate had been opened before the reset.
- R3: With the gate closed, `addr_o[20]` is 0 and the result is the sum modulo 100000h; FFFF:0010 (exactly 1 MiB) gives 0, and FFFF:0011 gives 1.
- R4: With the gate open, `addr_o` is the full 21-bit sum; FFFF:FFFF gives 10FFEFh with `wrap_o` = 0.
- R5: `wrap_o` is 1 exactly when the unmasked sum has bit 20 set and the gate is closed. It is 0 for every sum below 1 MiB.
- R6: The gate setting changes only on a clock edge where `gate_wr_i` is 1. A change of `gate_pass_i` without the strobe has no effect on `addr_o` or `wrap_o`.
- R7: The gate flop loads `gate_pass_i` on the rising edge where `gate_wr_i` is 1 (1 = pass the carry, 0 = mask). The new setting shows on `addr_o` after that edge and not before it.
- R8: Distinct pairs that alias give the same address; B000:8000 and B200:6000 both give B8000h.
- R9: `norm_seg_o` equals `phys_i` divided by 16, and `norm_off_o` equals `phys_i` modulo 16 with its upper 12 bits zero. For example, B8000h gives B800:0000.
- R10: Feeding a normalized pair back in as segment and offset reproduces the original physical address; FFFFFh gives FFFF:000F, which maps back to FFFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the gate flop |
| rst_n | input | 1 | Synchronous active-low reset; closes the gate |
| gate_wr_i | input | 1 | Strobe that loads the gate setting |
| gate_pass_i | input | 1 | Gate value to load: 1 passes the carry into bit 20, 0 masks it |
| seg_i | input | 16 | Segment value |
| off_i | input | 16 | Offset value |
| phys_i | input | 20 | Physical address to normalize |
| addr_o | output | 21 | Formed physical address |
| wrap_o | output | 1 | High when a carry into bit 20 was masked |
| norm_seg_o | output | 16 | Segment part of the normalized pair |
| norm_off_o | output | 16 | Offset part of the normalized pair, 0 to 0Fh |

## Verification
The bench checks the exact 1 MiB boundary and its neighbour, FFFF:0010 and FFFF:0011. A design that masked or compared at the wrong bit would give the wrong address at these two points, or miss the wrap flag. It runs the maximum pair FFFF:FFFF in both gate settings. An adder with a 20-bit result would lose 10FFEFh, and a flag that ignored the gate would rise while the gate is open. It toggles the gate value without the strobe and samples one cycle on each side of a strobed write. This exposes a flop that loads freely or at the wrong time. It also resets with the gate open, which catches a reset that leaves the gate alone. Finally, it runs normalization both ways. A normalizer that kept the wrong nibble would break the B800:0000 case and the round trip back to the same address.

// File: rtl/seg_addr_pkg.sv
// Package: shared widths and the gate-mode encoding for the segmented
// address generator. Assumes the segment shift is narrower than the offset.
package seg_addr_pkg;

    localparam int SEG_W_DEF   = 16;
    localparam int OFF_W_DEF   = 16;
    localparam int SHIFT_DEF   = 4;

    // Gate setting held in the control flop.
    typedef enum logic {
        GATE_MASK = 1'b0,   // bit 20 forced to zero, 1 MiB wraparound
        GATE_PASS = 1'b1    // carry into bit 20 reaches the output
    } gate_mode_e;

endpackage

// File: rtl/seg_gate_reg.sv
// Gate control flop. It holds the bit-20 gate setting, loads it only on a
// write strobe, and resets synchronously (active low) into the masking
// state. Assumes the strobe is synchronous to clk.
module seg_gate_reg
    import seg_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       wdata_i,
    output gate_mode_e mode_o
);

    gate_mode_e mode_q;

    // Hold or load the gate setting; reset closes the gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= GATE_MASK;
        end else if (wr_i) begin
            mode_q <= gate_mode_e'(wdata_i);
        end
    end

    assign mode_o = mode_q;

    // R6: without a strobe the setting holds.
    p_hold_without_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mode_q));

    // R7: a strobe loads the presented value.
    p_strobe_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mode_q == gate_mode_e'($past(wdata_i))));

endmodule

// File: rtl/seg_linear_adder.sv
// Combinational segment:offset adder. It forms segment * 2^SHIFT + offset at
// full width, then applies the bit-20 gate: in masking mode the top bit is
// cleared and the wrap flag reports that a carry was dropped. Assumes
// OFF_W <= SEG_W + SHIFT so the offset fits under the shifted segment.
module seg_linear_adder
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int SHIFT = SHIFT_DEF,
    localparam int PA_W  = SEG_W + SHIFT,
    localparam int OUT_W = PA_W + 1
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    input  gate_mode_e       mode_i,
    output logic [OUT_W-1:0] addr_o,
    output logic             wrap_o
);

    logic [OUT_W-1:0] seg_ext;
    logic [OUT_W-1:0] off_ext;
    logic [OUT_W-1:0] raw_sum;
    logic             carry_top;

    // Place the segment above SHIFT zero bits and widen both operands.
    always_comb begin
        seg_ext = {1'b0, seg_i, {SHIFT{1'b0}}};
        off_ext = OUT_W'(off_i);
    end

    // Full-width sum; its top bit is the carry past the base address range.
    always_comb begin
        raw_sum   = seg_ext + off_ext;
        carry_top = raw_sum[OUT_W-1];
    end

    // Apply the gate: mask the top bit or let it through, and flag a drop.
    always_comb begin
        if (mode_i == GATE_PASS) begin
            addr_o = raw_sum;
            wrap_o = 1'b0;
        end else begin
            addr_o = {1'b0, raw_sum[PA_W-1:0]};
            wrap_o = carry_top;
        end
    end

endmodule

// File: rtl/seg_normalizer.sv
// Combinational normalizer. It splits a physical address into the unique
// segment:offset pair whose offset lies in 0 .. 2^SHIFT-1. Assumes
// OFF_W >= SHIFT; a wider offset is zero-filled above the low SHIFT bits.
module seg_normalizer
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int SHIFT = SHIFT_DEF,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [PA_W-1:0]  phys_i,
    output logic [SEG_W-1:0] seg_o,
    output logic [OFF_W-1:0] off_o
);

    // Segment is the address divided by 2^SHIFT.
    always_comb begin
        seg_o = phys_i[PA_W-1:SHIFT];
    end

    // Offset is the remainder; pad with zeros when the offset is wider.
    generate
        if (OFF_W > SHIFT) begin : g_pad
            assign off_o = {{(OFF_W-SHIFT){1'b0}}, phys_i[SHIFT-1:0]};
        end else begin : g_exact
            assign off_o = phys_i[SHIFT-1:0];
        end
    endgenerate

endmodule

// File: rtl/seg_addr_gen.sv
// Top of the real-mode segmented address generator. It ties together the
// gate flop, the combinational adder and the normalizer. Only the gate
// setting is registered; address and normalized outputs follow the inputs
// within the same cycle.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int SHIFT = SHIFT_DEF,
    localparam int PA_W  = SEG_W + SHIFT,
    localparam int OUT_W = PA_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_wr_i,
    input  logic             gate_pass_i,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [PA_W-1:0]  phys_i,
    output logic [OUT_W-1:0] addr_o,
    output logic             wrap_o,
    output logic [SEG_W-1:0] norm_seg_o,
    output logic [OFF_W-1:0] norm_off_o
);

    gate_mode_e gate_mode;

    // Gate setting flop.
    seg_gate_reg u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (gate_wr_i),
        .wdata_i (gate_pass_i),
        .mode_o  (gate_mode)
    );

    // Segment:offset to physical address with the bit-20 gate.
    seg_linear_adder #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_add (
        .seg_i  (seg_i),
        .off_i  (off_i),
        .mode_i (gate_mode),
        .addr_o (addr_o),
        .wrap_o (wrap_o)
    );

    // Physical address to normalized segment:offset.
    seg_normalizer #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_norm (
        .phys_i (phys_i),
        .seg_o  (norm_seg_o),
        .off_o  (norm_off_o)
    );

    // R1: the shifted segment never touches the low nibble of the address.
    p_low_bits_from_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[SHIFT-1:0] == off_i[SHIFT-1:0]);

    // R3: a closed gate never lets bit 20 out.
    p_mask_clears_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode == GATE_MASK) |-> !addr_o[OUT_W-1]);

    // R4, R5: an open gate never reports a wrap.
    p_pass_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_mode == GATE_PASS) |-> !wrap_o);

    // R9: the normalized offset stays below 2^SHIFT.
    p_norm_offset_small_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_off_o >> SHIFT) == '0);

    // R10: the normalized pair recombines to the input address.
    p_norm_roundtrip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (PA_W'({norm_seg_o, {SHIFT{1'b0}}}) + PA_W'(norm_off_o)) == phys_i);

endmodule

// File: tb/seg_addr_gen_test.sv
// Directed bench for seg_addr_gen: one task per scenario, each checking its
// own results against values computed from the requirements.
module seg_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_wr_i = 1'b0;
    logic        gate_pass_i = 1'b0;
    logic [15:0] seg_i = '0;
    logic [15:0] off_i = '0;
    logic [19:0] phys_i = '0;
    logic [20:0] addr_o;
    logic        wrap_o;
    logic [15:0] norm_seg_o;
    logic [15:0] norm_off_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    seg_addr_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_wr_i   (gate_wr_i),
        .gate_pass_i (gate_pass_i),
        .seg_i       (seg_i),
        .off_i       (off_i),
        .phys_i      (phys_i),
        .addr_o      (addr_o),
        .wrap_o      (wrap_o),
        .norm_seg_o  (norm_seg_o),
        .norm_off_o  (norm_off_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a pair and let the combinational path settle.
    task automatic apply(input logic [15:0] s, input logic [15:0] o);
        seg_i = s;
        off_i = o;
        #1;
    endtask

    // Strobe a gate value on the next rising edge, then settle after it.
    task automatic write_gate(input logic v);
        @(negedge clk);
        gate_wr_i   = 1'b1;
        gate_pass_i = v;
        @(posedge clk);
        #1;
        gate_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        apply(16'hFFFF, 16'hFFFF);
        chk("R2 reset addr", 32'(addr_o), 32'h0FFEF);
        chk("R2 reset wrap", 32'(wrap_o), 32'h1);
    endtask

    task automatic t_basic_sum();
        apply(16'h258C, 16'h0012);
        chk("R1 258C:0012", 32'(addr_o), 32'h258D2);
        chk("R5 no wrap below 1MiB", 32'(wrap_o), 32'h0);
        apply(16'h0000, 16'h0000);
        chk("R1 zero", 32'(addr_o), 32'h00000);
        apply(16'h1234, 16'hABCD);
        chk("R1 1234:ABCD", 32'(addr_o), 32'h1CF0D);
    endtask

    task automatic t_alias();
        apply(16'hB000, 16'h8000);
        chk("R8 B000:8000", 32'(addr_o), 32'hB8000);
        apply(16'hB200, 16'h6000);
        chk("R8 B200:6000", 32'(addr_o), 32'hB8000);
    endtask

    task automatic t_masked_wrap();
        apply(16'hFFFF, 16'h0010);
        chk("R3 1MiB to 0", 32'(addr_o), 32'h00000);
        chk("R5 wrap at 1MiB", 32'(wrap_o), 32'h1);
        apply(16'hFFFF, 16'h0011);
        chk("R3 1MiB+1 to 1", 32'(addr_o), 32'h00001);
        apply(16'hFFFF, 16'h000F);
        chk("R3 just below 1MiB", 32'(addr_o), 32'hFFFFF);
        chk("R5 no wrap at FFFFF", 32'(wrap_o), 32'h0);
    endtask

    task automatic t_gate_timing();
        apply(16'hFFFF, 16'hFFFF);
        @(negedge clk);
        gate_wr_i   = 1'b1;
        gate_pass_i = 1'b1;
        #1;
        chk("R7 before edge", 32'(addr_o), 32'h0FFEF);
        @(posedge clk);
        #1;
        gate_wr_i = 1'b0;
        chk("R7 after edge", 32'(addr_o), 32'h10FFEF);
        chk("R4 open wrap", 32'(wrap_o), 32'h0);
        apply(16'h258C, 16'h0012);
        chk("R1 open gate", 32'(addr_o), 32'h258D2);
    endtask

    task automatic t_no_strobe();
        apply(16'hFFFF, 16'hFFFF);
        gate_pass_i = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R6 no strobe keeps pass", 32'(addr_o), 32'h10FFEF);
        write_gate(1'b0);
        chk("R3 closed again", 32'(addr_o), 32'h0FFEF);
        gate_pass_i = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R6 no strobe keeps mask", 32'(addr_o), 32'h0FFEF);
        chk("R6 wrap still flagged", 32'(wrap_o), 32'h1);
    endtask

    task automatic t_reset_closes();
        write_gate(1'b1);
        apply(16'hFFFF, 16'hFFFF);
        chk("R4 opened", 32'(addr_o), 32'h10FFEF);
        do_reset();
        apply(16'hFFFF, 16'hFFFF);
        chk("R2 reset closes gate", 32'(addr_o), 32'h0FFEF);
    endtask

    task automatic t_normalize();
        phys_i = 20'hB8000;
        #1;
        chk("R9 B8000 seg", 32'(norm_seg_o), 32'hB800);
        chk("R9 B8000 off", 32'(norm_off_o), 32'h0000);
        phys_i = 20'h258D2;
        #1;
        chk("R9 258D2 seg", 32'(norm_seg_o), 32'h258D);
        chk("R9 258D2 off", 32'(norm_off_o), 32'h0002);
    endtask

    task automatic t_roundtrip();
        logic [15:0] s;
        logic [15:0] o;
        phys_i = 20'hFFFFF;
        #1;
        s = norm_seg_o;
        o = norm_off_o;
        chk("R10 FFFFF off", 32'(o), 32'h000F);
        apply(s, o);
        chk("R10 FFFFF back", 32'(addr_o), 32'hFFFFF);
        phys_i = 20'h3A5C7;
        #1;
        s = norm_seg_o;
        o = norm_off_o;
        apply(s, o);
        chk("R10 3A5C7 back", 32'(addr_o), 32'h3A5C7);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_basic_sum();
        t_alias();
        t_masked_wrap();
        t_gate_timing();
        t_no_strobe();
        t_reset_closes();
        t_normalize();
        t_roundtrip();
        finish_run();
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule